// File: doc/BRIEF.md
# Prescaled Interval Timer

This block measures time in coarse steps. A free-running binary divider runs on the system clock. A three-bit selection field picks one of eight divider outputs, and each rising edge of that output becomes a single-cycle enable. An 8-bit counter advances on each enable. When the counter wraps from 255 back to 0, it raises a sticky interrupt request. That request stays set until the interrupt-acknowledge input clears it.

Software programs the block through a small register bus. A write-only control register holds four things: the tap selection, two stored enable bits (passed straight to outputs for other logic), and a one-shot clear bit. A read-only count register returns the current count. After reset the slowest tap is active, so the first interval after reset is as long as possible. With the defaults, tap n clocks the counter every 2^(n+3) system cycles.

Top module: `ivt_timer`

## Requirements
- R1: After reset the count reads 0, `irq_flag`, `wdog_en` and `pclk_en` are 0, and the tap field holds 111, so the counter advances every 1024 cycles.
- R2: The control register is at address 0xC7. Its bits 2:0 pick the tap, with value s giving one count step every 2^(s+3) clock cycles (8, 16, ... 1024). A new tap takes effect from the cycle after the write.
- R3: The count goes from 255 to 0 on the same clock edge that sets `irq_flag`. The flag does not rise at any other time.
- R4: `irq_flag` stays set until a cycle with `irq_ack` high clears it. If the acknowledge and a wrap happen in the same cycle, the flag stays set.
- R5: Writing 1 to control bit 3 makes the count read 0 at the second clock edge after the write. The clear bit drops by itself, so counting then resumes. A clear beats an increment in the same cycle.
- R6: The clear bit does not reset the divider. Count steps after a clear keep the same phase, modulo the tap period, as the steps before it.
- R7: Reading address 0xC8 returns the count. Reading 0xC7, or any other address, returns 0.
- R8: Control bit 5 drives `wdog_en` and bit 4 drives `pclk_en`. Bits 7 and 6 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_ack | input | 1 | Clears the interrupt request |
| irq_flag | output | 1 | Sticky overflow interrupt request |
| wdog_en | output | 1 | Stored enable bit 5 |
| pclk_en | output | 1 | Stored enable bit 4 |

## Verification
A wrong tap selection or a divider fault shows up as a wrong spacing between count changes on the read port. The bench measures that spacing at the second step after any write, so a fault appears within twice the tap period. A counter that skips, sticks or clears late shows at the first sample after the expected edge. A flag that is raised early, lost under acknowledge, or left uncleared is caught at the wrap itself or one cycle after the acknowledge. The divider phase is compared across a clear, which exposes a clear wired to the wrong register within two tap periods.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
   // control register bit positions (bits 2:0 form the tap field)
   localparam int CLR_POS  = 3;
   localparam int PCLK_POS = 4;
   localparam int WDOG_POS = 5;
   localparam int CTRL_MIN_W = WDOG_POS + 1;

   typedef struct packed {
      logic wdog;
      logic pclk;
   } ivt_enables_t;
endpackage

// File: rtl/ivt_prescaler.sv
module ivt_prescaler #(
   parameter int SEL_W    = 3,
   parameter int TAP_BASE = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel_i,
   output logic             tick_o
);
   localparam int NTAP  = 2 ** SEL_W;
   localparam int DIV_W = TAP_BASE + NTAP - 1;

   if (TAP_BASE < 2) begin : g_bad_base
      $error("ivt_prescaler: TAP_BASE must be at least 2");
   end

   logic [DIV_W-1:0] div_q;
   logic [NTAP-1:0]  tap_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div_q <= '0;
      else        div_q <= div_q + 1'b1;
   end

   // tap g fires one cycle before divider bit (TAP_BASE+g-1) rises
   for (genvar g = 0; g < NTAP; g++) begin : g_tap
      localparam int K = TAP_BASE + g;
      assign tap_tick[g] = (&div_q[K-2:0]) & ~div_q[K-1];
   end

   assign tick_o = tap_tick[sel_i];

   // R2: taps never fire together, so a tap change cannot double-step
   a_r2_taps_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tap_tick));
endmodule

// File: rtl/ivt_ctrl.sv
module ivt_ctrl
   import ivt_pkg::*;
#(
   parameter int                SEL_W     = 3,
   parameter int                ADDR_W    = 8,
   parameter int                DATA_W    = 8,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 'hC7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [SEL_W-1:0]  sel_o,
   output logic              clr_o,
   output ivt_enables_t      en_o
);
   if (DATA_W < CTRL_MIN_W || SEL_W > CLR_POS) begin : g_bad_layout
      $error("ivt_ctrl: control fields do not fit the data width");
   end

   logic wr_hit;
   logic clr_req;
   logic unused_wdata;

   assign wr_hit       = wr_i && (addr_i == CTRL_ADDR);
   assign clr_req      = wr_hit && wdata_i[CLR_POS];
   assign unused_wdata = ^wdata_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_o <= '1;
         clr_o <= 1'b0;
         en_o  <= '0;
      end else begin
         clr_o <= clr_req;
         if (wr_hit) begin
            sel_o   <= wdata_i[SEL_W-1:0];
            en_o.wdog <= wdata_i[WDOG_POS];
            en_o.pclk <= wdata_i[PCLK_POS];
         end
      end
   end

   // R5: the clear bit lasts one cycle unless written again
   a_r5_clear_self_drops: assert property (@(posedge clk) disable iff (!rst_n)
      clr_o && !clr_req |=> !clr_o);
   // R8: enables move only on a write to the control address
   a_r8_enables_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> $stable(en_o));
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             clr_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             ovf_o
);
   assign ovf_o = tick_i && !clr_i && (&cnt_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_o <= '0;
      else if (clr_i)  cnt_o <= '0;
      else if (tick_i) cnt_o <= cnt_o + 1'b1;
   end

   // R5: clear beats increment
   a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> cnt_o == '0);
   // R2: one step per tap enable
   a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i && !clr_i |=> cnt_o == CNT_W'($past(cnt_o) + 1'b1));
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i && !clr_i |=> $stable(cnt_o));
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
   import ivt_pkg::*;
#(
   parameter int                CNT_W     = 8,
   parameter int                SEL_W     = 3,
   parameter int                TAP_BASE  = 3,
   parameter int                ADDR_W    = 8,
   parameter int                DATA_W    = 8,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 'hC7,
   parameter logic [ADDR_W-1:0] CNT_ADDR  = 'hC8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              irq_ack,
   output logic              irq_flag,
   output logic              wdog_en,
   output logic              pclk_en
);
   if (DATA_W < CNT_W || CTRL_ADDR == CNT_ADDR) begin : g_bad_map
      $error("ivt_timer: count must fit the bus and addresses must differ");
   end

   logic [SEL_W-1:0] tap_sel;
   logic             clr_pulse;
   ivt_enables_t     enables;
   logic             tap_tick;
   logic [CNT_W-1:0] count;
   logic             wrap;

   ivt_ctrl #(
      .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .wr_i(bus_wr),
      .wdata_i(bus_wdata), .sel_o(tap_sel), .clr_o(clr_pulse), .en_o(enables)
   );

   ivt_prescaler #(.SEL_W(SEL_W), .TAP_BASE(TAP_BASE)) u_presc (
      .clk(clk), .rst_n(rst_n), .sel_i(tap_sel), .tick_o(tap_tick)
   );

   ivt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick_i(tap_tick), .clr_i(clr_pulse),
      .cnt_o(count), .ovf_o(wrap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       irq_flag <= 1'b0;
      else if (wrap)    irq_flag <= 1'b1;
      else if (irq_ack) irq_flag <= 1'b0;
   end

   assign bus_rdata = (bus_addr == CNT_ADDR) ? DATA_W'(count) : '0;
   assign wdog_en   = enables.wdog;
   assign pclk_en   = enables.pclk;

   // R3: a wrap always leaves the flag set
   a_r3_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> irq_flag);
   // R4: flag is sticky without acknowledge, cleared by it otherwise
   a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      irq_flag && !irq_ack |=> irq_flag);
   a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack && !wrap |=> !irq_flag);
   // R3: the flag only rises together with a wrap to zero
   a_r3_rise_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flag) |-> count == '0);
endmodule

// File: tb/ivt_timer_bench.sv
module ivt_timer_bench;
   localparam logic [7:0] CTRL_A = 8'hC7;
   localparam logic [7:0] CNT_A  = 8'hC8;
   localparam int NVEC = 8;
   // control write data and expected step period in cycles
   localparam logic [7:0] VEC_DATA [NVEC] = '{8'h00, 8'h01, 8'h02, 8'h03,
                                              8'h04, 8'h05, 8'hC2, 8'h46};
   localparam int VEC_PER [NVEC] = '{8, 16, 32, 64, 128, 256, 32, 512};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = CNT_A;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       irq_ack = 1'b0;
   logic       irq_flag, wdog_en, pclk_en;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   ivt_timer u_ivt_timer (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_ack(irq_ack),
      .irq_flag(irq_flag), .wdog_en(wdog_en), .pclk_en(pclk_en)
   );

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr_ctrl(input logic [7:0] d);
      @(negedge clk);
      bus_addr = CTRL_A; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = CNT_A;
      #1;
   endtask

   // waits at negedges for the count to change; returns cycle of change
   task automatic next_step(output int t);
      logic [7:0] v0;
      v0 = bus_rdata;
      while (bus_rdata == v0) begin
         @(negedge clk); #1;
      end
      t = cyc;
   endtask

   task automatic measure(output int per);
      int t1, t2;
      next_step(t1);
      next_step(t2);
      per = t2 - t1;
   endtask

   task automatic wait_count(input logic [7:0] v);
      while (bus_rdata != v) begin
         @(negedge clk); #1;
      end
   endtask

   initial begin
      int per, t1, t2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      chk("R1 count", bus_rdata, 0);
      chk("R1 irq_flag", irq_flag, 0);
      chk("R1 wdog_en", wdog_en, 0);
      chk("R1 pclk_en", pclk_en, 0);
      measure(per);
      chk("R1 slowest tap period", per, 1024);

      // R2/R8: table of tap writes
      for (int i = 0; i < NVEC; i++) begin
         wr_ctrl(VEC_DATA[i]);
         measure(per);
         chk(i >= 6 ? "R8 upper bits ignored, period" : "R2 tap period",
             per, VEC_PER[i]);
      end

      // R8: enable bits
      wr_ctrl(8'hE0);
      chk("R8 wdog_en", wdog_en, 1);
      chk("R8 pclk_en", pclk_en, 0);
      wr_ctrl(8'hD0);
      chk("R8 wdog_en", wdog_en, 0);
      chk("R8 pclk_en", pclk_en, 1);

      // R7: reads
      bus_addr = CTRL_A; #1;
      chk("R7 control reads zero", bus_rdata, 0);
      bus_addr = 8'h00; #1;
      chk("R7 other address reads zero", bus_rdata, 0);
      bus_addr = CNT_A; #1;

      // R5/R6: clear with fastest tap, phase kept
      wr_ctrl(8'h00);
      wait_count(8'd3);
      next_step(t1);
      @(negedge clk);
      bus_addr = CTRL_A; bus_wdata = 8'h08; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = CNT_A;
      @(negedge clk); #1;
      chk("R5 count cleared", bus_rdata, 0);
      next_step(t2);
      chk("R5 counting resumes", bus_rdata, 1);
      chk("R6 divider phase kept", (t2 - t1) % 8, 0);

      // R4: acknowledge at the wrap keeps flag set
      irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0; #1;
      wait_count(8'd255);
      chk("R3 no early flag", irq_flag, 0);
      irq_ack = 1'b1;
      wait_count(8'd0);
      irq_ack = 1'b0;
      chk("R4 ack at wrap keeps flag", irq_flag, 1);
      repeat (20) @(negedge clk);
      #1;
      chk("R4 flag sticky", irq_flag, 1);
      irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0; #1;
      chk("R4 ack clears flag", irq_flag, 0);

      // R3: plain wrap
      wait_count(8'd255);
      chk("R3 flag low at 255", irq_flag, 0);
      wait_count(8'd0);
      chk("R3 flag set with wrap", irq_flag, 1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule